// File: doc/BRIEF.md
# Oscillator source switch sequencer

This block steers the system clock selection among three sources: an untrimmed RC oscillator, a trimmed RC oscillator and a crystal oscillator. A caller presents a target source with a one-cycle request. The sequencer then walks a fixed series of single-cycle steps. It raises the target oscillator's ready-bar line and pulses its power-up strobe, loads a trim word, and releases ready-bar. It then changes the clock multiplexer select using a clear-hold, write-select, set-hold handshake. The oscillators, the fuse array, the always-on trim store, the RC calibrator and the crystal calibration engine all sit outside. The block sees them only as plain inputs and drives them with write strobes.

The block only takes glitch-safe paths. A move from the untrimmed RC to the crystal first completes a full switch to the trimmed RC. RC trim comes from the always-on saved code when that code is valid, otherwise from a valid fuse code. When neither is valid, the oscillator keeps its default trim and an RC calibration runs after the select switch. The crystal keeps a valid saved code untouched, or else takes a valid fuse code. Its calibration engine is started with a keyed write pair unless its done bit is already set. The final crystal trim is written back with its enable bit. The block checks the engine's result for consistency and flags any mismatch.

States: IDLE, HOLD (matching request), R_PREP, R_TRIM, R_REL (RC preparation), SW_HCLR, SW_SEL, SW_HSET (select handshake), R_CAL_GO, R_CAL_WAIT, R_CAL_WR (RC calibration), X_PREP, X_TRIM, X_CHK, X_KEY0, X_KEY1, X_WAIT, X_EVAL, X_REL (crystal preparation and calibration), DONE. Transitions:
- IDLE goes to HOLD on a request equal to the current source.
- IDLE goes to SW_HCLR for the untrimmed RC.
- IDLE goes to R_PREP for the trimmed RC, or for the crystal when the untrimmed RC is selected.
- IDLE goes to X_PREP for the crystal from the trimmed RC.
- SW_HSET goes to R_CAL_GO when RC calibration is pending, to X_PREP when the trimmed-RC leg was only an intermediate step, and to DONE otherwise.
- X_CHK skips to X_EVAL when the engine is already done.
- HOLD, R_CAL_WR (RC target) and the final select handshake go to DONE, then IDLE.

Top module: `osc_switch_seq`

## Requirements
- R1: After reset the current source `sel_stat` is 3 (untrimmed RC), `busy`, `cal_err` and `osc_readyb` are 0, and no strobe is active.
- R2: The select encoding is crystal = 0, trimmed RC = 2, untrimmed RC = 3. A request equal to `sel_stat` produces exactly one `hold_set` pulse and no `hold_clr` or `sel_wr`, followed by `done`.
- R3: A crystal request while the untrimmed RC is selected writes the select twice, first 2 and then 0. A select write of 0 never happens while `sel_stat` is 3.
- R4: `osc_readyb` bit 1 (trimmed RC) or bit 0 (crystal) is set, with a one-cycle power-up strobe, before that oscillator's trim is written. Both bits are 0 again by the time `hold_clr` is pulsed.
- R5: RC trim priority is saved code, then fuse code. The written word carries the code in its low bits and the enable at bit RC_TRIM_W. With neither code valid, no trim is written before the switch. A calibration start then follows the select handshake, and the calibrated code is written with the enable set.
- R6: For the crystal, a valid saved code causes no trim write before calibration. Otherwise a valid fuse code is written as {1, code} (enable at bit 4 for 4-bit trim).
- R7: If calibration-status bit 0 (done) is clear, the block writes 0 and then 0x60221413 to the key port in consecutive cycles. If that bit is set, no key write occurs.
- R8: After crystal calibration the final trim, taken from status bits 4:1, is written back with enable bit 4 set.
- R9: With status flag bit 5 high, `cal_err` is set when final trim is greater than or equal to the 4-bit maximum. With the flag low, it is set when final trim differs from the maximum. The next accepted request clears it.
- R10: Every select change is `hold_clr`, `sel_wr`, `hold_set` in three consecutive cycles, and `sel_stat` takes the written value.
- R11: `busy` is high from the cycle after acceptance until `done`. Requests presented while busy are ignored.
- R12: A request with code 1 is ignored: `busy` stays low and no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Switch request strobe |
| req_src | input | 2 | Requested source code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| sel_stat | output | 2 | Currently selected source |
| cal_err | output | 1 | Crystal calibration consistency error |
| rc_saved_vld | input | 1 | Always-on RC trim code valid |
| rc_saved_code | input | RC_TRIM_W | Always-on RC trim code |
| rc_fuse_vld | input | 1 | Fuse RC trim code valid |
| rc_fuse_code | input | RC_TRIM_W | Fuse RC trim code |
| rc_cal_done | input | 1 | RC calibrator finished |
| rc_cal_code | input | RC_TRIM_W | RC calibrator result, valid with done |
| xtl_saved_vld | input | 1 | Always-on crystal trim code valid |
| xtl_fuse_vld | input | 1 | Fuse crystal trim code valid |
| xtl_fuse_code | input | XTL_TRIM_W | Fuse crystal trim code |
| xcal_stat | input | XTL_TRIM_W+2 | Calibration engine status: done, trim, flag |
| xcal_max | input | XTL_TRIM_W | Maximum crystal trim setting |
| pwr_up_rc | output | 1 | Clear trimmed-RC power disable |
| pwr_up_xtl | output | 1 | Clear crystal power disable |
| osc_readyb | output | 2 | Ready-bar: bit 1 trimmed RC, bit 0 crystal |
| rc_trim_wr | output | 1 | RC trim write strobe |
| rc_trim_word | output | RC_TRIM_W+1 | RC trim word with enable on top |
| xtl_trim_wr | output | 1 | Crystal trim write strobe |
| xtl_trim_word | output | XTL_TRIM_W+1 | Crystal trim word with enable on top |
| rc_cal_start | output | 1 | Start RC calibration |
| xcal_key_wr | output | 1 | Calibration engine key write strobe |
| xcal_key_data | output | 32 | Calibration engine key value |
| hold_clr | output | 1 | Clear select hold |
| sel_wr | output | 1 | Select write strobe |
| sel_val | output | 2 | Select value, valid with sel_wr |
| hold_set | output | 1 | Set select hold |

## Verification
The switch function is tried from each starting source toward each target. Untrimmed-to-crystal is the only path that must show two select writes, so it is separated from trimmed-to-crystal. The RC trim source is varied over saved, fuse-only and neither, which separates a priority inversion from a missing calibration. The crystal engine is presented with its done bit clear and set, so a missing key pair can be told apart from a spurious one. A table of calibration results on both sides of the maximum, for both flag values, pins the error rule at its boundaries. Requests with code 1, requests matching the current source, and requests held during a busy sequence show that nothing outside an accepted request moves the select.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;

    localparam logic [1:0]  SRC_XTL  = 2'd0;
    localparam logic [1:0]  SRC_BAD  = 2'd1;
    localparam logic [1:0]  SRC_RCT  = 2'd2;
    localparam logic [1:0]  SRC_RCR  = 2'd3;
    localparam logic [31:0] XCAL_KEY = 32'h6022_1413;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_HOLD,
        ST_R_PREP,
        ST_R_TRIM,
        ST_R_REL,
        ST_SW_HCLR,
        ST_SW_SEL,
        ST_SW_HSET,
        ST_R_CAL_GO,
        ST_R_CAL_WAIT,
        ST_R_CAL_WR,
        ST_X_PREP,
        ST_X_TRIM,
        ST_X_CHK,
        ST_X_KEY0,
        ST_X_KEY1,
        ST_X_WAIT,
        ST_X_EVAL,
        ST_X_REL,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/osc_trim_pick.sv
module osc_trim_pick #(
    parameter int W = 28
) (
    input  logic         saved_vld,
    input  logic [W-1:0] saved_code,
    input  logic         fuse_vld,
    input  logic [W-1:0] fuse_code,
    output logic [W-1:0] code,
    output logic         use_dflt
);
    // Saved always-on code wins over fuse; neither means keep default.
    always_comb begin
        if (saved_vld) begin
            code     = saved_code;
            use_dflt = 1'b0;
        end else if (fuse_vld) begin
            code     = fuse_code;
            use_dflt = 1'b0;
        end else begin
            code     = '0;
            use_dflt = 1'b1;
        end
    end
endmodule

// File: rtl/xcal_check.sv
module xcal_check #(
    parameter int XW = 4
) (
    input  logic [XW+1:0] stat,
    input  logic [XW-1:0] max_trim,
    output logic          eng_done,
    output logic [XW-1:0] fin_trim,
    output logic          mismatch
);
    logic flag;

    assign eng_done = stat[0];
    assign fin_trim = stat[XW:1];
    assign flag     = stat[XW+1];

    // Flag high: trim must be below max. Flag low: trim must equal max.
    assign mismatch = flag ? (fin_trim >= max_trim) : (fin_trim != max_trim);
endmodule

// File: rtl/osc_seq_ctrl.sv
module osc_seq_ctrl
    import osc_seq_pkg::*;
#(
    parameter int RCW = 28,
    parameter int XW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [1:0]     req_src,
    input  logic [RCW-1:0] rc_pick_code,
    input  logic           rc_use_dflt,
    input  logic           rc_cal_done,
    input  logic [RCW-1:0] rc_cal_code,
    input  logic           xtl_saved_vld,
    input  logic           xtl_fuse_vld,
    input  logic [XW-1:0]  xtl_fuse_code,
    input  logic           xc_done,
    input  logic [XW-1:0]  xc_trim,
    input  logic           xc_err,
    output logic           busy,
    output logic           done,
    output logic [1:0]     sel_stat,
    output logic           cal_err,
    output logic           pwr_up_rc,
    output logic           pwr_up_xtl,
    output logic [1:0]     osc_readyb,
    output logic           rc_trim_wr,
    output logic [RCW:0]   rc_trim_word,
    output logic           xtl_trim_wr,
    output logic [XW:0]    xtl_trim_word,
    output logic           rc_cal_start,
    output logic           xcal_key_wr,
    output logic [31:0]    xcal_key_data,
    output logic           hold_clr,
    output logic           sel_wr,
    output logic [1:0]     sel_val,
    output logic           hold_set
);

    seq_state_e     state, state_nx;
    logic [1:0]     sel_q, tgt_q, step_q;
    logic           need_cal_q, err_q;
    logic [1:0]     rdyb_q;
    logic [RCW-1:0] cal_q;
    logic           acc;

    assign acc = (state == ST_IDLE) && req_valid && (req_src != SRC_BAD);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (acc) begin
                    if (req_src == sel_q)        state_nx = ST_HOLD;
                    else if (req_src == SRC_RCR) state_nx = ST_SW_HCLR;
                    else if (req_src == SRC_RCT) state_nx = ST_R_PREP;
                    else if (sel_q == SRC_RCR)   state_nx = ST_R_PREP;
                    else                         state_nx = ST_X_PREP;
                end
            end
            ST_HOLD:       state_nx = ST_DONE;
            ST_R_PREP:     state_nx = ST_R_TRIM;
            ST_R_TRIM:     state_nx = ST_R_REL;
            ST_R_REL:      state_nx = ST_SW_HCLR;
            ST_SW_HCLR:    state_nx = ST_SW_SEL;
            ST_SW_SEL:     state_nx = ST_SW_HSET;
            ST_SW_HSET: begin
                if (step_q == SRC_RCT && need_cal_q)        state_nx = ST_R_CAL_GO;
                else if (step_q == SRC_RCT && tgt_q == SRC_XTL) state_nx = ST_X_PREP;
                else                                         state_nx = ST_DONE;
            end
            ST_R_CAL_GO:   state_nx = ST_R_CAL_WAIT;
            ST_R_CAL_WAIT: if (rc_cal_done) state_nx = ST_R_CAL_WR;
            ST_R_CAL_WR:   state_nx = (tgt_q == SRC_XTL) ? ST_X_PREP : ST_DONE;
            ST_X_PREP:     state_nx = ST_X_TRIM;
            ST_X_TRIM:     state_nx = ST_X_CHK;
            ST_X_CHK:      state_nx = xc_done ? ST_X_EVAL : ST_X_KEY0;
            ST_X_KEY0:     state_nx = ST_X_KEY1;
            ST_X_KEY1:     state_nx = ST_X_WAIT;
            ST_X_WAIT:     if (xc_done) state_nx = ST_X_EVAL;
            ST_X_EVAL:     state_nx = ST_X_REL;
            ST_X_REL:      state_nx = ST_SW_HCLR;
            ST_DONE:       state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // Sequence context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q      <= SRC_RCR;
            tgt_q      <= SRC_RCR;
            step_q     <= SRC_RCR;
            need_cal_q <= 1'b0;
            err_q      <= 1'b0;
            rdyb_q     <= 2'b00;
            cal_q      <= '0;
        end else begin
            if (acc) begin
                tgt_q      <= req_src;
                step_q     <= (req_src == SRC_RCR) ? SRC_RCR : SRC_RCT;
                need_cal_q <= 1'b0;
                err_q      <= 1'b0;
            end
            case (state)
                ST_R_PREP:     rdyb_q[1] <= 1'b1;
                ST_R_TRIM:     need_cal_q <= rc_use_dflt;
                ST_R_REL:      rdyb_q[1] <= 1'b0;
                ST_SW_SEL:     sel_q <= step_q;
                ST_R_CAL_WAIT: if (rc_cal_done) cal_q <= rc_cal_code;
                ST_R_CAL_WR:   need_cal_q <= 1'b0;
                ST_X_PREP: begin
                    rdyb_q[0] <= 1'b1;
                    step_q    <= SRC_XTL;
                end
                ST_X_EVAL:     err_q <= xc_err;
                ST_X_REL:      rdyb_q[0] <= 1'b0;
                default: ;
            endcase
        end
    end

    // Output decode (Moore)
    logic rc_wr_pick, xtl_wr_fuse;
    assign rc_wr_pick  = (state == ST_R_TRIM) && !rc_use_dflt;
    assign xtl_wr_fuse = (state == ST_X_TRIM) && !xtl_saved_vld && xtl_fuse_vld;

    always_comb begin
        busy          = (state != ST_IDLE);
        done          = (state == ST_DONE);
        sel_stat      = sel_q;
        cal_err       = err_q;
        osc_readyb    = rdyb_q;
        pwr_up_rc     = (state == ST_R_PREP);
        pwr_up_xtl    = (state == ST_X_PREP);
        rc_cal_start  = (state == ST_R_CAL_GO);
        hold_clr      = (state == ST_SW_HCLR);
        sel_wr        = (state == ST_SW_SEL);
        sel_val       = step_q;
        hold_set      = (state == ST_SW_HSET) || (state == ST_HOLD);
        xcal_key_wr   = (state == ST_X_KEY0) || (state == ST_X_KEY1);
        xcal_key_data = (state == ST_X_KEY1) ? XCAL_KEY : 32'd0;
        rc_trim_wr    = rc_wr_pick || (state == ST_R_CAL_WR);
        rc_trim_word  = '0;
        if (state == ST_R_CAL_WR) rc_trim_word = {1'b1, cal_q};
        else if (rc_wr_pick)      rc_trim_word = {1'b1, rc_pick_code};
        xtl_trim_wr   = xtl_wr_fuse || (state == ST_X_EVAL);
        xtl_trim_word = '0;
        if (state == ST_X_EVAL)   xtl_trim_word = {1'b1, xc_trim};
        else if (xtl_wr_fuse)     xtl_trim_word = {1'b1, xtl_fuse_code};
    end

    // Assertions
    a_r2_match_hold_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_src == sel_stat) |=> (hold_set && !hold_clr && !sel_wr));

    a_r3_no_raw_to_xtl: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && sel_val == SRC_XTL) |-> (sel_stat != SRC_RCR));

    a_r4_xtl_trim_ready: assert property (@(posedge clk) disable iff (!rst_n)
        xtl_trim_wr |-> osc_readyb[0]);

    a_r4_ready_released: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |-> (osc_readyb == 2'b00));

    a_r7_key_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (xcal_key_wr && xcal_key_data != 32'd0) |->
            ($past(xcal_key_wr) && $past(xcal_key_data) == 32'd0));

    a_r10_sel_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |-> $past(hold_clr));

    a_r10_hset_after_sel: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (hold_set && sel_stat == $past(sel_val)));

    a_r10_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hold_clr, sel_wr, hold_set}));

    a_r11_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

endmodule

// File: rtl/osc_switch_seq.sv
module osc_switch_seq #(
    parameter int RC_TRIM_W  = 28,
    parameter int XTL_TRIM_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_src,
    output logic                  busy,
    output logic                  done,
    output logic [1:0]            sel_stat,
    output logic                  cal_err,
    input  logic                  rc_saved_vld,
    input  logic [RC_TRIM_W-1:0]  rc_saved_code,
    input  logic                  rc_fuse_vld,
    input  logic [RC_TRIM_W-1:0]  rc_fuse_code,
    input  logic                  rc_cal_done,
    input  logic [RC_TRIM_W-1:0]  rc_cal_code,
    input  logic                  xtl_saved_vld,
    input  logic                  xtl_fuse_vld,
    input  logic [XTL_TRIM_W-1:0] xtl_fuse_code,
    input  logic [XTL_TRIM_W+1:0] xcal_stat,
    input  logic [XTL_TRIM_W-1:0] xcal_max,
    output logic                  pwr_up_rc,
    output logic                  pwr_up_xtl,
    output logic [1:0]            osc_readyb,
    output logic                  rc_trim_wr,
    output logic [RC_TRIM_W:0]    rc_trim_word,
    output logic                  xtl_trim_wr,
    output logic [XTL_TRIM_W:0]   xtl_trim_word,
    output logic                  rc_cal_start,
    output logic                  xcal_key_wr,
    output logic [31:0]           xcal_key_data,
    output logic                  hold_clr,
    output logic                  sel_wr,
    output logic [1:0]            sel_val,
    output logic                  hold_set
);

    logic [RC_TRIM_W-1:0]  rc_pick_code;
    logic                  rc_use_dflt;
    logic                  xc_done;
    logic [XTL_TRIM_W-1:0] xc_trim;
    logic                  xc_err;

    osc_trim_pick #(.W(RC_TRIM_W)) u_rc_pick (
        .saved_vld (rc_saved_vld),
        .saved_code(rc_saved_code),
        .fuse_vld  (rc_fuse_vld),
        .fuse_code (rc_fuse_code),
        .code      (rc_pick_code),
        .use_dflt  (rc_use_dflt)
    );

    xcal_check #(.XW(XTL_TRIM_W)) u_xcheck (
        .stat    (xcal_stat),
        .max_trim(xcal_max),
        .eng_done(xc_done),
        .fin_trim(xc_trim),
        .mismatch(xc_err)
    );

    osc_seq_ctrl #(.RCW(RC_TRIM_W), .XW(XTL_TRIM_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_src      (req_src),
        .rc_pick_code (rc_pick_code),
        .rc_use_dflt  (rc_use_dflt),
        .rc_cal_done  (rc_cal_done),
        .rc_cal_code  (rc_cal_code),
        .xtl_saved_vld(xtl_saved_vld),
        .xtl_fuse_vld (xtl_fuse_vld),
        .xtl_fuse_code(xtl_fuse_code),
        .xc_done      (xc_done),
        .xc_trim      (xc_trim),
        .xc_err       (xc_err),
        .busy         (busy),
        .done         (done),
        .sel_stat     (sel_stat),
        .cal_err      (cal_err),
        .pwr_up_rc    (pwr_up_rc),
        .pwr_up_xtl   (pwr_up_xtl),
        .osc_readyb   (osc_readyb),
        .rc_trim_wr   (rc_trim_wr),
        .rc_trim_word (rc_trim_word),
        .xtl_trim_wr  (xtl_trim_wr),
        .xtl_trim_word(xtl_trim_word),
        .rc_cal_start (rc_cal_start),
        .xcal_key_wr  (xcal_key_wr),
        .xcal_key_data(xcal_key_data),
        .hold_clr     (hold_clr),
        .sel_wr       (sel_wr),
        .sel_val      (sel_val),
        .hold_set     (hold_set)
    );

endmodule

// File: tb/tb_osc_switch_seq.sv
module tb_osc_switch_seq;

    localparam int CLK_PERIOD = 10;
    localparam int RCW = 28;
    localparam int XW  = 4;
    localparam logic [31:0]    KEY_WORD = 32'h6022_1413;
    localparam logic [RCW-1:0] CODE_A   = 28'h1234567;
    localparam logic [RCW-1:0] CODE_B   = 28'h7654321;
    localparam logic [RCW-1:0] CODE_CAL = 28'h0ABCDEF;

    // {trim[9:6], flag[5], max[4:1], expected err[0]}
    localparam int NVEC = 7;
    localparam logic [9:0] XVEC [0:NVEC-1] = '{
        {4'd3,  1'b1, 4'd8,  1'b0},
        {4'd8,  1'b1, 4'd8,  1'b1},
        {4'd9,  1'b1, 4'd8,  1'b1},
        {4'd8,  1'b0, 4'd8,  1'b0},
        {4'd5,  1'b0, 4'd8,  1'b1},
        {4'd15, 1'b0, 4'd15, 1'b0},
        {4'd0,  1'b1, 4'd1,  1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_src = 2'd0;
    logic busy, done, cal_err;
    logic [1:0] sel_stat;
    logic rc_saved_vld = 1'b0, rc_fuse_vld = 1'b0;
    logic [RCW-1:0] rc_saved_code = CODE_A, rc_fuse_code = CODE_B;
    logic rc_cal_done = 1'b0;
    logic [RCW-1:0] rc_cal_code = CODE_CAL;
    logic xtl_saved_vld = 1'b1, xtl_fuse_vld = 1'b0;
    logic [XW-1:0] xtl_fuse_code = 4'hA;
    logic [XW+1:0] xcal_stat;
    logic [XW-1:0] xcal_max;
    logic pwr_up_rc, pwr_up_xtl, rc_trim_wr, xtl_trim_wr, rc_cal_start;
    logic [1:0] osc_readyb;
    logic [RCW:0] rc_trim_word;
    logic [XW:0] xtl_trim_word;
    logic xcal_key_wr, hold_clr, sel_wr, hold_set;
    logic [31:0] xcal_key_data;
    logic [1:0] sel_val;

    osc_switch_seq #(.RC_TRIM_W(RCW), .XTL_TRIM_W(XW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .busy(busy), .done(done), .sel_stat(sel_stat), .cal_err(cal_err),
        .rc_saved_vld(rc_saved_vld), .rc_saved_code(rc_saved_code),
        .rc_fuse_vld(rc_fuse_vld), .rc_fuse_code(rc_fuse_code),
        .rc_cal_done(rc_cal_done), .rc_cal_code(rc_cal_code),
        .xtl_saved_vld(xtl_saved_vld), .xtl_fuse_vld(xtl_fuse_vld),
        .xtl_fuse_code(xtl_fuse_code), .xcal_stat(xcal_stat), .xcal_max(xcal_max),
        .pwr_up_rc(pwr_up_rc), .pwr_up_xtl(pwr_up_xtl), .osc_readyb(osc_readyb),
        .rc_trim_wr(rc_trim_wr), .rc_trim_word(rc_trim_word),
        .xtl_trim_wr(xtl_trim_wr), .xtl_trim_word(xtl_trim_word),
        .rc_cal_start(rc_cal_start), .xcal_key_wr(xcal_key_wr),
        .xcal_key_data(xcal_key_data), .hold_clr(hold_clr), .sel_wr(sel_wr),
        .sel_val(sel_val), .hold_set(hold_set)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // RC calibrator model: done pulse three cycles after start
    logic [2:0] rcc_cnt = 3'd0;
    always @(posedge clk) begin
        rc_cal_done <= 1'b0;
        if (rc_cal_start) rcc_cnt <= 3'd3;
        else if (rcc_cnt != 3'd0) begin
            rcc_cnt <= rcc_cnt - 3'd1;
            if (rcc_cnt == 3'd1) rc_cal_done <= 1'b1;
        end
    end

    // Crystal calibration engine model
    logic x_done = 1'b0, x_armed = 1'b0, x_reset_cmd = 1'b0;
    logic [2:0] x_cnt = 3'd0;
    logic [XW-1:0] x_trim_v = 4'd6, x_max_v = 4'd8;
    logic x_flag_v = 1'b1;
    always @(posedge clk) begin
        if (x_reset_cmd) begin
            x_done <= 1'b0; x_armed <= 1'b0; x_cnt <= 3'd0;
        end else if (xcal_key_wr && xcal_key_data == 32'd0) begin
            x_done <= 1'b0; x_armed <= 1'b1;
        end else if (xcal_key_wr && xcal_key_data == KEY_WORD && x_armed) begin
            x_armed <= 1'b0; x_cnt <= 3'd4;
        end else if (x_cnt != 3'd0) begin
            x_cnt <= x_cnt - 3'd1;
            if (x_cnt == 3'd1) x_done <= 1'b1;
        end
    end
    assign xcal_stat = {x_flag_v, x_trim_v, x_done};
    assign xcal_max  = x_max_v;

    // Event monitor, sampled on the falling edge
    int cyc = 0;
    int n_hset, n_hclr, n_sel, n_rcw, n_xw, n_key, n_done, n_calgo, n_pwr_rc, n_pwr_x;
    int cyc_hclr, cyc_sel, cyc_hset, cyc_calgo;
    logic [1:0]  sel_log [0:3];
    logic [31:0] key_log [0:3];
    logic [RCW:0] rc_last;
    logic rc_rdy_first;
    logic [XW:0] xw_first, xw_last;
    logic x_rdy_all;

    task automatic clear_logs();
        n_hset = 0; n_hclr = 0; n_sel = 0; n_rcw = 0; n_xw = 0; n_key = 0;
        n_done = 0; n_calgo = 0; n_pwr_rc = 0; n_pwr_x = 0;
        cyc_hclr = 0; cyc_sel = 0; cyc_hset = 0; cyc_calgo = 0;
        rc_last = '0; rc_rdy_first = 1'b0; xw_first = '0; xw_last = '0; x_rdy_all = 1'b1;
        for (int i = 0; i < 4; i++) begin sel_log[i] = 2'd1; key_log[i] = 32'hFFFF_FFFF; end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (hold_set) begin n_hset++; cyc_hset = cyc; end
        if (hold_clr) begin n_hclr++; cyc_hclr = cyc; end
        if (sel_wr) begin
            if (n_sel < 4) sel_log[n_sel] = sel_val;
            n_sel++; cyc_sel = cyc;
        end
        if (rc_trim_wr) begin
            if (n_rcw == 0) rc_rdy_first = osc_readyb[1];
            rc_last = rc_trim_word; n_rcw++;
        end
        if (xtl_trim_wr) begin
            if (n_xw == 0) xw_first = xtl_trim_word;
            xw_last = xtl_trim_word;
            x_rdy_all = x_rdy_all & osc_readyb[0];
            n_xw++;
        end
        if (xcal_key_wr) begin
            if (n_key < 4) key_log[n_key] = xcal_key_data;
            n_key++;
        end
        if (rc_cal_start) begin n_calgo++; cyc_calgo = cyc; end
        if (pwr_up_rc) n_pwr_rc++;
        if (pwr_up_xtl) n_pwr_x++;
        if (done) n_done++;
    end

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [1:0] src);
        clear_logs();
        @(negedge clk); req_valid = 1'b1; req_src = src;
        @(negedge clk); req_valid = 1'b0;
        for (int i = 0; i < 300 && n_done == 0; i++) @(negedge clk);
        chk(n_done == 1, "R11 sequence completes with one done", n_done, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic x_engine_clear();
        @(negedge clk); x_reset_cmd = 1'b1;
        @(negedge clk); x_reset_cmd = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog expired act=0x%0h exp=0x%0h", cyc, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_logs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(sel_stat == 2'd3, "R1 reset sel_stat", sel_stat, 3);
        chk(!busy && !cal_err, "R1 reset busy/cal_err", {busy, cal_err}, 0);
        chk(osc_readyb == 2'b00, "R1 reset readyb", osc_readyb, 0);
        chk(!hold_set && !hold_clr && !sel_wr, "R1 reset strobes", {hold_set, hold_clr, sel_wr}, 0);

        // R12 invalid code ignored
        clear_logs();
        @(negedge clk); req_valid = 1'b1; req_src = 2'd1;
        @(negedge clk); req_valid = 1'b0;
        chk(!busy, "R12 code 1 not accepted", busy, 0);
        repeat (3) @(negedge clk);
        chk(n_hset == 0 && n_sel == 0 && n_hclr == 0, "R12 no strobes", n_hset + n_sel + n_hclr, 0);
        chk(sel_stat == 2'd3, "R12 selection unchanged", sel_stat, 3);

        // R2 matching request: hold only
        do_req(2'd3);
        chk(n_hset == 1 && n_hclr == 0 && n_sel == 0, "R2 hold only",
            {n_hset[7:0], n_hclr[7:0], n_sel[7:0]}, 24'h010000);
        chk(sel_stat == 2'd3, "R2 selection unchanged", sel_stat, 3);

        // R5 saved code wins over fuse; R4 readyb; R10 order
        rc_saved_vld = 1'b1; rc_fuse_vld = 1'b1;
        do_req(2'd2);
        chk(n_rcw == 1 && rc_last == {1'b1, CODE_A}, "R5 saved code written", rc_last, {1'b1, CODE_A});
        chk(rc_rdy_first == 1'b1 && n_pwr_rc == 1, "R4 rc readyb set and powered before trim",
            {rc_rdy_first, n_pwr_rc[3:0]}, 5'h11);
        chk(osc_readyb == 2'b00, "R4 readyb released", osc_readyb, 0);
        chk(cyc_sel == cyc_hclr + 1 && cyc_hset == cyc_sel + 1, "R10 clear/select/set order",
            {cyc_hclr[15:0], cyc_sel[15:0], cyc_hset[15:0]}, 0);
        chk(sel_stat == 2'd2 && n_calgo == 0, "R10 sel_stat follows write", sel_stat, 2);

        do_req(2'd3);
        chk(n_sel == 1 && sel_log[0] == 2'd3 && n_rcw == 0, "R10 back to untrimmed", sel_log[0], 3);

        // R5 fuse used when saved invalid
        rc_saved_vld = 1'b0;
        do_req(2'd2);
        chk(n_rcw == 1 && rc_last == {1'b1, CODE_B}, "R5 fuse code written", rc_last, {1'b1, CODE_B});
        do_req(2'd3);

        // R5 default -> calibration after switch
        rc_fuse_vld = 1'b0;
        do_req(2'd2);
        chk(n_calgo == 1 && cyc_calgo > cyc_sel, "R5 calibration after select", cyc_calgo, cyc_sel + 1);
        chk(n_rcw == 1 && rc_last == {1'b1, CODE_CAL}, "R5 calibrated code written", rc_last, {1'b1, CODE_CAL});

        // R3 untrimmed -> crystal goes via trimmed RC; R7 keyed start; R8 write-back
        do_req(2'd3);
        rc_saved_vld = 1'b1;
        x_trim_v = 4'd6; x_flag_v = 1'b1; x_max_v = 4'd8;
        do_req(2'd0);
        chk(n_sel == 2 && sel_log[0] == 2'd2 && sel_log[1] == 2'd0, "R3 two-step select",
            {sel_log[0], sel_log[1]}, 4'b1000);
        chk(sel_stat == 2'd0, "R3 final crystal", sel_stat, 0);
        chk(n_key == 2 && key_log[0] == 32'd0 && key_log[1] == KEY_WORD, "R7 key pair",
            key_log[1], KEY_WORD);
        chk(n_xw == 1 && xw_last == 5'h16, "R8 final trim with enable", xw_last, 5'h16);
        chk(x_rdy_all && n_pwr_x == 1 && osc_readyb == 2'b00, "R4 crystal readyb window",
            {x_rdy_all, osc_readyb}, 3'b100);
        chk(cal_err == 1'b0, "R9 consistent result", cal_err, 0);

        // R7 skip when engine already done
        do_req(2'd2);
        x_trim_v = 4'd7;
        do_req(2'd0);
        chk(n_key == 0, "R7 no key when done set", n_key, 0);
        chk(n_sel == 1 && sel_log[0] == 2'd0, "R3 trimmed to crystal single step", n_sel, 1);
        chk(xw_last == 5'h17, "R8 skipped path write-back", xw_last, 5'h17);

        // R6 fuse crystal trim when saved invalid
        do_req(2'd2);
        xtl_saved_vld = 1'b0; xtl_fuse_vld = 1'b1;
        x_trim_v = 4'd9; x_flag_v = 1'b0; x_max_v = 4'd9;
        do_req(2'd0);
        chk(n_xw == 2 && xw_first == 5'h1A, "R6 fuse trim written first", xw_first, 5'h1A);
        chk(xw_last == 5'h19 && cal_err == 1'b0, "R8 final trim after fuse", xw_last, 5'h19);

        // R11 requests while busy ignored
        clear_logs();
        @(negedge clk); req_valid = 1'b1; req_src = 2'd2;
        @(negedge clk); req_src = 2'd3;
        chk(busy == 1'b1, "R11 busy after accept", busy, 1);
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 300 && n_done == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(n_sel == 1 && sel_log[0] == 2'd2 && n_done == 1, "R11 held request ignored",
            {n_sel[3:0], sel_log[0]}, 6'h06);
        chk(!busy && sel_stat == 2'd2, "R11 idle after done", {busy, sel_stat}, 3'b010);

        // R9 result table
        for (int v = 0; v < NVEC; v++) begin
            x_trim_v = XVEC[v][9:6]; x_flag_v = XVEC[v][5]; x_max_v = XVEC[v][4:1];
            x_engine_clear();
            do_req(2'd0);
            chk(cal_err == XVEC[v][0], "R9 consistency flag", cal_err, XVEC[v][0]);
            chk(xw_last == {1'b1, XVEC[v][9:6]}, "R8 table write-back", xw_last, {1'b1, XVEC[v][9:6]});
            do_req(2'd2);
            chk(cal_err == 1'b0, "R9 cleared by next request", cal_err, 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule